// File: doc/BRIEF.md
# Three-Way Instruction Dispatch Queue

This block sits in the front end of a superscalar core, between the shared cache port and three execution units. It keeps a small compacting buffer of fetched instruction words. Each word carries a 2-bit class tag that names the unit it goes to: integer, floating point or branch. In any one cycle it can send one instruction to each unit that is ready. When a unit stalls, instructions for the other units keep flowing past the stalled ones. Floating-point work first goes into a short holding buffer, so the queue can keep draining while the floating-point unit is busy.

The block also decides who uses the cache port. It asks for a refill group of up to eight words only when enough slots are free and no refill is already outstanding. A data request always takes the port in preference to the refill. A flush empties the buffer and the floating-point holding buffer in one cycle, and it discards any refill data still on its way.

Top module: `dispatch_queue`

## Requirements
- R1: The buffer holds DEPTH (8) entries and starts empty after reset. A refill writes up to FILL_W (8) words in one cycle, with the word count in `fillCount`. Word j of a refill gets address `fillAddr + 4*j` and class tag `fillClass[2j+1:2j]`, where 00 = integer, 01 = floating point and 10 = branch.
- R2: Each cycle, each unit is offered the oldest buffered instruction of its own class. At most one instruction per unit is dispatched per cycle, so three in total. Within each class, instructions leave in program order.
- R3: A unit that holds its ready low does not block instructions of the other classes. Those may leave from behind older instructions of the stalled class.
- R4: Floating-point instructions move from the buffer into a FPQ_DEPTH (2) entry holding buffer. This still happens while the floating-point unit is stalled. Once the holding buffer is full, further floating-point instructions wait in the main buffer. The holding buffer's head is what the floating-point unit sees.
- R5: While a unit's valid is high and its ready is low, the offered instruction and address stay unchanged until the unit accepts them or a flush occurs.
- R6: A refill request (`fetchGnt`) is made only when at least FILL_W slots are free, no refill is outstanding and no flush is active. After a request, no further request is made until its data returns.
- R7: `dataReq` is granted in the same cycle through `dataGnt`. While it is high, `fetchGnt` stays low.
- R8: `flush` empties the buffer and the holding buffer within one cycle and dispatches nothing in that cycle. Refill data for a request made before the flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all queues and drop outstanding refill |
| dataReq | input | 1 | Data access wants the cache port |
| dataGnt | output | 1 | Cache port given to the data access |
| fetchGnt | output | 1 | Cache port given to an instruction refill request |
| fillValid | input | 1 | Refill data present |
| fillCount | input | $clog2(FILL_W+1) | Number of valid words in the refill |
| fillAddr | input | AW | Address of refill word 0 |
| fillWords | input | FILL_W*IW | Refill words, word j at bits j*IW |
| fillClass | input | FILL_W*2 | Class tag per refill word |
| intReady | input | 1 | Integer unit accepts |
| intValid | output | 1 | Integer instruction offered |
| intInstr | output | IW | Integer instruction word |
| intAddr | output | AW | Integer instruction address |
| fpuReady | input | 1 | Floating-point unit accepts |
| fpuValid | output | 1 | Floating-point instruction offered |
| fpuInstr | output | IW | Floating-point instruction word |
| fpuAddr | output | AW | Floating-point instruction address |
| brReady | input | 1 | Branch unit accepts |
| brValid | output | 1 | Branch instruction offered |
| brInstr | output | IW | Branch instruction word |
| brAddr | output | AW | Branch instruction address |

## Verification
The properties assume that refill data arrives only after a `fetchGnt` and at most once per grant. They also assume that no word carries class code 11. The bench's memory model returns exactly one refill group a fixed number of cycles after each grant it observes, and it only ever issues the three legal codes. The properties treat a unit's ready as free to change every cycle. The bench therefore drives the ready lines as constant high, constant low and two different toggling patterns, and it places flushes both against a full buffer and against a refill in flight.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
package dq_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'b00,
    CLS_FP   = 2'b01,
    CLS_BR   = 2'b10,
    CLS_NONE = 2'b11
  } unitClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;
    logic fillTake;
    logic intFire;
    logic brFire;
    logic fpTake;
    logic fpqPop;
  } dqStrobe_t;
endpackage

// File: rtl/dq_ctrl.sv
`timescale 1ns/1ps
module dq_ctrl
  import dq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int FILL_W    = 8,
  parameter int FPQ_DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           flush,
  input  logic                           dataReq,
  input  logic                           fillValid,
  input  logic                           intReady,
  input  logic                           fpuReady,
  input  logic                           brReady,
  input  logic [DEPTH-1:0]               entValid,
  input  logic [2*DEPTH-1:0]             entClass,
  input  logic [$clog2(FPQ_DEPTH+1)-1:0] fpqCount,
  output dqStrobe_t                      stb,
  output logic [DEPTH-1:0]               intPick,
  output logic [DEPTH-1:0]               fpPick,
  output logic [DEPTH-1:0]               brPick,
  output logic                           intValid,
  output logic                           fpuValid,
  output logic                           brValid,
  output logic                           dataGnt,
  output logic                           fetchGnt
);
  logic pending;
  logic dropNext;
  logic fpuFire;
  logic fpRoom;
  int   usedCnt;

  // oldest entry of each class: lowest index wins
  always_comb begin
    intPick = '0;
    fpPick  = '0;
    brPick  = '0;
    usedCnt = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entValid[i]) begin
        case (entClass[2*i +: 2])
          CLS_INT: begin intPick = '0; intPick[i] = 1'b1; end
          CLS_FP:  begin fpPick  = '0; fpPick[i]  = 1'b1; end
          CLS_BR:  begin brPick  = '0; brPick[i]  = 1'b1; end
          default: ;
        endcase
      end
      usedCnt = usedCnt + int'(entValid[i]);
    end
  end

  always_comb begin
    intValid     = (|intPick) && !flush;
    brValid      = (|brPick) && !flush;
    fpuValid     = (fpqCount != '0) && !flush;
    fpuFire      = fpuValid && fpuReady;
    fpRoom       = (int'(fpqCount) < FPQ_DEPTH) || fpuFire;
    dataGnt      = dataReq;
    fetchGnt     = !pending && !flush && !dataReq && ((DEPTH - usedCnt) >= FILL_W);
    stb.flush    = flush;
    stb.fillTake = fillValid && pending && !dropNext && !flush;
    stb.intFire  = intValid && intReady;
    stb.brFire   = brValid && brReady;
    stb.fpTake   = (|fpPick) && fpRoom && !flush;
    stb.fpqPop   = fpuFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      dropNext <= 1'b0;
    end else if (fillValid) begin
      pending  <= 1'b0;
      dropNext <= 1'b0;
    end else begin
      if (fetchGnt) pending <= 1'b1;
      if (flush && pending) dropNext <= 1'b1;
    end
  end
endmodule

// File: rtl/dq_datapath.sv
`timescale 1ns/1ps
module dq_datapath
  import dq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int FILL_W    = 8,
  parameter int IW        = 32,
  parameter int AW        = 32,
  parameter int FPQ_DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dqStrobe_t                      stb,
  input  logic [DEPTH-1:0]               intPick,
  input  logic [DEPTH-1:0]               fpPick,
  input  logic [DEPTH-1:0]               brPick,
  input  logic [$clog2(FILL_W+1)-1:0]    fillCount,
  input  logic [AW-1:0]                  fillAddr,
  input  logic [FILL_W*IW-1:0]           fillWords,
  input  logic [FILL_W*2-1:0]            fillClass,
  output logic [DEPTH-1:0]               entValid,
  output logic [2*DEPTH-1:0]             entClass,
  output logic [$clog2(FPQ_DEPTH+1)-1:0] fpqCount,
  output logic [IW-1:0]                  intInstr,
  output logic [AW-1:0]                  intAddr,
  output logic [IW-1:0]                  brInstr,
  output logic [AW-1:0]                  brAddr,
  output logic [IW-1:0]                  fpuInstr,
  output logic [AW-1:0]                  fpuAddr
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int FQW   = $clog2(FPQ_DEPTH + 1);

  logic [IW-1:0]    word  [DEPTH];
  logic [AW-1:0]    addr  [DEPTH];
  logic [1:0]       cls   [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [IW-1:0]    nWord [DEPTH];
  logic [AW-1:0]    nAddr [DEPTH];
  logic [1:0]       nCls  [DEPTH];
  logic [DEPTH-1:0] nVld;
  logic [DEPTH-1:0] take;
  logic [IDX_W:0]   wp;

  logic [IW-1:0]    fqW [FPQ_DEPTH];
  logic [AW-1:0]    fqA [FPQ_DEPTH];
  logic [FQW-1:0]   fqCnt;
  logic [FQW-1:0]   wrIdx;
  logic [IW-1:0]    pushW;
  logic [AW-1:0]    pushA;

  assign take = (intPick & {DEPTH{stb.intFire}}) | (brPick & {DEPTH{stb.brFire}}) |
                (fpPick & {DEPTH{stb.fpTake}});

  // compact survivors toward the head, then append the refill group
  always_comb begin
    nWord = word;
    nAddr = addr;
    nCls  = cls;
    nVld  = '0;
    wp    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !take[i]) begin
        nWord[wp[IDX_W-1:0]] = word[i];
        nAddr[wp[IDX_W-1:0]] = addr[i];
        nCls[wp[IDX_W-1:0]]  = cls[i];
        nVld[wp[IDX_W-1:0]]  = 1'b1;
        wp = wp + (IDX_W+1)'(1);
      end
    end
    if (stb.fillTake) begin
      for (int j = 0; j < FILL_W; j++) begin
        if (j < int'(fillCount) && wp < (IDX_W+1)'(DEPTH)) begin
          nWord[wp[IDX_W-1:0]] = fillWords[j*IW +: IW];
          nAddr[wp[IDX_W-1:0]] = fillAddr + AW'(4 * j);
          nCls[wp[IDX_W-1:0]]  = fillClass[2*j +: 2];
          nVld[wp[IDX_W-1:0]]  = 1'b1;
          wp = wp + (IDX_W+1)'(1);
        end
      end
    end
    if (stb.flush) nVld = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) vld <= '0;
    else       vld <= nVld;
    word <= nWord;
    addr <= nAddr;
    cls  <= nCls;
  end

  // one-hot selection muxes
  always_comb begin
    intInstr = '0; intAddr = '0;
    brInstr  = '0; brAddr  = '0;
    pushW    = '0; pushA   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      intInstr |= word[i] & {IW{intPick[i]}};
      intAddr  |= addr[i] & {AW{intPick[i]}};
      brInstr  |= word[i] & {IW{brPick[i]}};
      brAddr   |= addr[i] & {AW{brPick[i]}};
      pushW    |= word[i] & {IW{fpPick[i]}};
      pushA    |= addr[i] & {AW{fpPick[i]}};
    end
  end

  // floating-point holding buffer, shifts toward slot 0
  assign wrIdx = fqCnt - FQW'(stb.fpqPop);

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) fqCnt <= '0;
    else fqCnt <= fqCnt + FQW'(stb.fpTake) - FQW'(stb.fpqPop);
    for (int q = 0; q < FPQ_DEPTH; q++) begin
      if (stb.fpqPop) begin
        fqW[q] <= (q == FPQ_DEPTH - 1) ? '0 : fqW[(q + 1) % FPQ_DEPTH];
        fqA[q] <= (q == FPQ_DEPTH - 1) ? '0 : fqA[(q + 1) % FPQ_DEPTH];
      end
      if (stb.fpTake && wrIdx == FQW'(q)) begin
        fqW[q] <= pushW;
        fqA[q] <= pushA;
      end
    end
  end

  always_comb begin
    entValid = vld;
    for (int i = 0; i < DEPTH; i++) entClass[2*i +: 2] = cls[i];
  end

  assign fpqCount = fqCnt;
  assign fpuInstr = fqW[0];
  assign fpuAddr  = fqA[0];
endmodule

// File: rtl/dispatch_queue.sv
`timescale 1ns/1ps
module dispatch_queue
  import dq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int FILL_W    = 8,
  parameter int IW        = 32,
  parameter int AW        = 32,
  parameter int FPQ_DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        dataReq,
  output logic                        dataGnt,
  output logic                        fetchGnt,
  input  logic                        fillValid,
  input  logic [$clog2(FILL_W+1)-1:0] fillCount,
  input  logic [AW-1:0]               fillAddr,
  input  logic [FILL_W*IW-1:0]        fillWords,
  input  logic [FILL_W*2-1:0]         fillClass,
  input  logic                        intReady,
  output logic                        intValid,
  output logic [IW-1:0]               intInstr,
  output logic [AW-1:0]               intAddr,
  input  logic                        fpuReady,
  output logic                        fpuValid,
  output logic [IW-1:0]               fpuInstr,
  output logic [AW-1:0]               fpuAddr,
  input  logic                        brReady,
  output logic                        brValid,
  output logic [IW-1:0]               brInstr,
  output logic [AW-1:0]               brAddr
);
  localparam int FQW = $clog2(FPQ_DEPTH + 1);

  dqStrobe_t          stb;
  logic [DEPTH-1:0]   intPick;
  logic [DEPTH-1:0]   fpPick;
  logic [DEPTH-1:0]   brPick;
  logic [DEPTH-1:0]   entValid;
  logic [2*DEPTH-1:0] entClass;
  logic [FQW-1:0]     fpqCount;

  dq_ctrl #(.DEPTH(DEPTH), .FILL_W(FILL_W), .FPQ_DEPTH(FPQ_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .dataReq(dataReq), .fillValid(fillValid),
    .intReady(intReady), .fpuReady(fpuReady), .brReady(brReady),
    .entValid(entValid), .entClass(entClass), .fpqCount(fpqCount),
    .stb(stb), .intPick(intPick), .fpPick(fpPick), .brPick(brPick),
    .intValid(intValid), .fpuValid(fpuValid), .brValid(brValid),
    .dataGnt(dataGnt), .fetchGnt(fetchGnt)
  );

  dq_datapath #(.DEPTH(DEPTH), .FILL_W(FILL_W), .IW(IW), .AW(AW), .FPQ_DEPTH(FPQ_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .intPick(intPick), .fpPick(fpPick), .brPick(brPick),
    .fillCount(fillCount), .fillAddr(fillAddr), .fillWords(fillWords), .fillClass(fillClass),
    .entValid(entValid), .entClass(entClass), .fpqCount(fpqCount),
    .intInstr(intInstr), .intAddr(intAddr), .brInstr(brInstr), .brAddr(brAddr),
    .fpuInstr(fpuInstr), .fpuAddr(fpuAddr)
  );
endmodule

// File: rtl/dispatch_queue_chk.sv
`timescale 1ns/1ps
module dispatch_queue_chk #(
  parameter int IW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          flush,
  input logic          dataReq,
  input logic          dataGnt,
  input logic          fetchGnt,
  input logic          intReady,
  input logic          intValid,
  input logic [IW-1:0] intInstr,
  input logic [AW-1:0] intAddr,
  input logic          fpuReady,
  input logic          fpuValid,
  input logic [IW-1:0] fpuInstr,
  input logic [AW-1:0] fpuAddr,
  input logic          brReady,
  input logic          brValid,
  input logic [IW-1:0] brInstr,
  input logic [AW-1:0] brAddr
);
  // R7
  data_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> (dataGnt && !fetchGnt));

  // R6
  single_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchGnt |=> !fetchGnt);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!intValid && !brValid && !fpuValid));

  // R5
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intValid && !intReady) |=> (flush || (intValid && $stable(intInstr) && $stable(intAddr))));

  // R5
  br_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !brReady) |=> (flush || (brValid && $stable(brInstr) && $stable(brAddr))));

  // R5
  fpu_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpuValid && !fpuReady) |=> (flush || (fpuValid && $stable(fpuInstr) && $stable(fpuAddr))));
endmodule

bind dispatch_queue dispatch_queue_chk #(.IW(IW), .AW(AW)) u_chk (.*);

// File: tb/dispatch_queue_bench.sv
`timescale 1ns/1ps
module dispatch_queue_bench;
  localparam int DEPTH = 8, FILL_W = 8, IW = 32, AW = 32, FPQ_DEPTH = 2;
  localparam int CNT_W = $clog2(FILL_W + 1);

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, dataReq = 1'b0, fillValid = 1'b0;
  logic [CNT_W-1:0] fillCount = '0;
  logic [AW-1:0] fillAddr = '0;
  logic [FILL_W*IW-1:0] fillWords = '0;
  logic [FILL_W*2-1:0] fillClass = '0;
  logic intReady = 1'b0, fpuReady = 1'b0, brReady = 1'b0;
  logic dataGnt, fetchGnt, intValid, fpuValid, brValid;
  logic [IW-1:0] intInstr, fpuInstr, brInstr;
  logic [AW-1:0] intAddr, fpuAddr, brAddr;

  dispatch_queue #(.DEPTH(DEPTH), .FILL_W(FILL_W), .IW(IW), .AW(AW), .FPQ_DEPTH(FPQ_DEPTH)) u_dispatch_queue (
    .clk(clk), .rstN(rstN), .flush(flush), .dataReq(dataReq), .dataGnt(dataGnt), .fetchGnt(fetchGnt),
    .fillValid(fillValid), .fillCount(fillCount), .fillAddr(fillAddr), .fillWords(fillWords),
    .fillClass(fillClass), .intReady(intReady), .intValid(intValid), .intInstr(intInstr),
    .intAddr(intAddr), .fpuReady(fpuReady), .fpuValid(fpuValid), .fpuInstr(fpuInstr),
    .fpuAddr(fpuAddr), .brReady(brReady), .brValid(brValid), .brInstr(brInstr), .brAddr(brAddr)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycle = 0, fires = 0, gntSeen = 0, serial = 0, lat = 0;
  int intMode = 0, fpMode = 0, brMode = 0;
  bit flushReq = 0, armFlush = 0, bPending = 0, bDrop = 0;
  logic [63:0] expInt[$], expFp[$], expBr[$];
  logic [33:0] progQ[$];
  logic [AW-1:0] nextAddr = 32'h0000_1000;

  function automatic logic readyOf(int mode, int cyc);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return cyc[0];
      default: return (cyc % 3) != 0;
    endcase
  endfunction

  task automatic note(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic popCmp(string req, string unit, logic [63:0] got, ref logic [63:0] q[$]);
    if (q.size() == 0) note(req, {unit, " unexpected dispatch"}, got, 64'hx);
    else note(req, {unit, " dispatch order"}, got, q.pop_front());
  endtask

  // drive phase: on the falling edge
  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      flush = flushReq;
      flushReq = 0;
      if (flush) begin
        expInt.delete(); expFp.delete(); expBr.delete();
        if (bPending) bDrop = 1;
      end
      fillValid = 1'b0;
      if (bPending && lat == 0) begin
        int n;
        n = (progQ.size() < FILL_W) ? progQ.size() : FILL_W;
        fillWords = '0; fillClass = '0;
        for (int j = 0; j < n; j++) begin
          logic [33:0] it;
          logic [63:0] e;
          it = progQ.pop_front();
          fillWords[j*IW +: IW] = it[31:0];
          fillClass[2*j +: 2] = it[33:32];
          e = {it[31:0], nextAddr + AW'(4 * j)};
          if (!bDrop && !flush) begin
            case (it[33:32])
              2'b00: expInt.push_back(e);
              2'b01: expFp.push_back(e);
              default: expBr.push_back(e);
            endcase
          end
        end
        fillAddr = nextAddr;
        fillCount = CNT_W'(n);
        fillValid = 1'b1;
        nextAddr = nextAddr + AW'(4 * n);
        bPending = 0;
        bDrop = 0;
      end
    end
    intReady = readyOf(intMode, cycle);
    fpuReady = readyOf(fpMode, cycle + 1);
    brReady  = readyOf(brMode, cycle);
    // observe phase: inputs settled, before the next rising edge
    #1;
    if (rstN) begin
      if (!flush) begin
        if (intValid && intReady) begin fires++; popCmp("R2", "int", {intInstr, intAddr}, expInt); end
        if (fpuValid && fpuReady) begin fires++; popCmp("R4", "fpu", {fpuInstr, fpuAddr}, expFp); end
        if (brValid && brReady)   begin fires++; popCmp("R3", "br",  {brInstr, brAddr}, expBr); end
      end
      if (fetchGnt) begin bPending = 1; lat = 2; gntSeen++; end
      else if (bPending && lat > 0) lat--;
      if (armFlush && bPending) begin flushReq = 1; armFlush = 0; end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(logic [1:0] c);
    progQ.push_back({c, 6'(c), 2'b11, 24'(serial)});
    serial++;
  endtask

  task automatic drain(string req);
    for (int k = 0; k < 600; k++) begin
      if (progQ.size() == 0 && expInt.size() == 0 && expFp.size() == 0 && expBr.size() == 0) break;
      waitCycles(1);
    end
    note(req, "left undispatched", 64'(expInt.size() + expFp.size() + expBr.size() + progQ.size()), 64'd0);
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g0, f0;
    waitCycles(5);
    // R1: empty after reset
    note("R1", "reset valids", {61'd0, intValid, fpuValid, brValid}, 64'd0);
    rstN = 1'b1;
    waitCycles(4);

    // R1 R2: mixed program, all units ready
    for (int i = 0; i < 20; i++) push((i % 4 == 3) ? 2'b00 : 2'((i * 5) % 3));
    drain("R1");
    note("R2", "dispatch count", 64'(fires), 64'd20);

    // R2: toggling readies
    intMode = 2; fpMode = 3; brMode = 2;
    for (int i = 0; i < 24; i++) push(2'((i * 7 + i / 5) % 3));
    drain("R2");
    intMode = 0; fpMode = 0; brMode = 0;

    // R3: integer unit stalled, others pass it
    intMode = 1;
    push(2'b00); push(2'b00); push(2'b01); push(2'b10);
    push(2'b01); push(2'b10); push(2'b01); push(2'b10);
    waitCycles(30);
    note("R3", "ints held", 64'(expInt.size()), 64'd2);
    note("R3", "others drained", 64'(expFp.size() + expBr.size()), 64'd0);
    intMode = 0;
    drain("R3");

    // R4 R6: three fp with stalled FPU, one stays in buffer, no refill
    fpMode = 1;
    push(2'b01); push(2'b01); push(2'b01); push(2'b00);
    waitCycles(30);
    g0 = gntSeen;
    waitCycles(15);
    note("R6", "refill while entry held", 64'(gntSeen - g0), 64'd0);
    note("R4", "fp pending", 64'(expFp.size()), 64'd3);
    fpMode = 0;
    drain("R4");

    // R4: two fp fit in holding buffer, buffer empties, refill resumes
    fpMode = 1;
    push(2'b01); push(2'b01); push(2'b00);
    waitCycles(30);
    g0 = gntSeen;
    waitCycles(15);
    note("R4", "refill after holding absorbs two", 64'(gntSeen > g0), 64'd1);
    fpMode = 0;
    drain("R4");

    // R7: data request wins the port
    dataReq = 1'b1;
    waitCycles(6);
    g0 = gntSeen;
    note("R7", "data grant / fetch grant", {62'd0, dataGnt, fetchGnt}, 64'd2);
    waitCycles(15);
    note("R7", "no fetch while data", 64'(gntSeen - g0), 64'd0);
    dataReq = 1'b0;
    waitCycles(10);
    note("R6", "fetch resumes", 64'(gntSeen > g0), 64'd1);

    // R8: flush a full stalled buffer
    intMode = 1; fpMode = 1; brMode = 1;
    for (int i = 0; i < 8; i++) push(2'(i % 3));
    waitCycles(30);
    note("R8", "valids before flush", {61'd0, intValid, fpuValid, brValid}, 64'h7);
    flushReq = 1;
    waitCycles(3);
    note("R8", "valids after flush", {61'd0, intValid, fpuValid, brValid}, 64'd0);

    // R8: refill in flight at flush is dropped
    for (int i = 0; i < 8; i++) push(2'(i % 3));
    armFlush = 1;
    waitCycles(20);
    intMode = 0; fpMode = 0; brMode = 0;
    f0 = fires;
    waitCycles(30);
    note("R8", "dispatches after dropped refill", 64'(fires - f0), 64'd0);
    note("R8", "program consumed", 64'(progQ.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule